// File: doc/BRIEF.md
# Receive FIFO with Programmable Level Flags

This block buffers 32-bit words arriving on a parallel input port until a DMA engine or a processor reads them out through a small register port. Each accepted word is stored in an inferred memory, and reads of the data register return the words in arrival order. A ready line tells the DMA engine that at least one word is waiting, so the engine can pull data on demand.

Software sets two levels in one threshold register: an almost-empty level and an almost-full level. The status register reports the fill state in inverted form: not empty, not almost empty, not almost full and not full. It also holds two sticky error bits. One is set when a word arrives while the FIFO is full. The other is set when the data register is read while the FIFO is empty. Both error bits are cleared by writing a one to them.

The control register has three actions. It can empty the FIFO, gate reception on or off, or reset the whole block. A whole-block reset also starts a settling period. During that period the FIFO neither accepts nor releases words. Two read-only registers report the FIFO depth and the current fill.

Top module: `rx_level_fifo`

## Requirements
- R1: After the synchronous reset, status reads 0x0000C000 (not-almost-full bit 14 and not-full bit 15 set, all else clear), the threshold register reads 0x00200020, control reads 0, fill reads 0 and `dma_ready` is low.
- R2: A word on `in_valid` is stored only while the enable bit (control bit 5) is set. A word offered while reception is disabled is dropped, and it sets no error bit.
- R3: A read strobe on the data register (read index 5) removes the oldest word. That word appears on `reg_rdata` one cycle after the strobe, so words come out in the order they were stored.
- R4: Status bit 12 is set when the FIFO holds at least one word. Status bit 15 is set while the fill is below DEPTH.
- R5: Status bit 13 is clear while the fill is at or below the almost-empty level, which is held in bits 15:0 of the threshold register (index 2). Otherwise bit 13 is set.
- R6: Status bit 14 is clear while the fill is at or above DEPTH minus the almost-full level, which is held in bits 23:16 of the threshold register. Otherwise bit 14 is set.
- R7: A word arriving while reception is enabled and the FIFO is full is dropped, and it sets sticky status bit 23 (overrun).
- R8: A data-register read while the FIFO is empty returns 0, leaves the fill at 0 and sets sticky status bit 22 (underrun).
- R9: Writing the status register (index 1) with bit 23 or bit 22 set clears that error bit. If an error event and its clear fall in the same cycle, the bit stays set.
- R10: A control write (index 0) with bit 2 set empties the FIFO at once. Bit 5 of the same write still sets or clears enable, and bit 2 reads back as 0.
- R11: A control write with bit 0 set does all of the following:
  - it empties the FIFO, clears enable and both error bits, and restores both levels to 32;
  - it makes control bit 0 (busy) read 1 for SETTLE_CYCLES cycles;
  - while busy, words are not stored, data reads return 0 and no error bit is set.
- R12: The size register (index 3) reads DEPTH and the fill register (index 4) reads the current word count, both in bits 19:0.
- R13: `dma_ready` is high exactly when the FIFO holds at least one word, and it changes on the same clock edge as the fill count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 32 | Input word |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_raddr | input | 3 | Register read index |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| dma_ready | output | 1 | At least one word is waiting |

## Verification
The hardest states to reach are the ones that need an event and a clear, or an access and a reset, to meet in the same cycle. The first is an underrun whose write-one-to-clear arrives in the very cycle a new underrun happens. The bench uses separate read and write index ports to issue both in one cycle. The second is FIFO traffic during the settling window after a whole-block reset. The bench turns enable back on, pushes a word and reads the data register before the busy count expires, then waits out the window and confirms that reception works again. The threshold edges are reached by filling the FIFO one word at a time with small programmed levels, sampling status at each boundary and then pushing one word past full.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W = 3;
  localparam int LEVEL_DEFAULT = 32;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL  = 3'd0,
    IDX_STAT  = 3'd1,
    IDX_LEVEL = 3'd2,
    IDX_SIZE  = 3'd3,
    IDX_FILL  = 3'd4,
    IDX_DATA  = 3'd5
  } rxf_idx_e;

  // control bits
  localparam int CB_SRST  = 0;
  localparam int CB_FLUSH = 2;
  localparam int CB_EN    = 5;
  // status bits
  localparam int SB_NEMPTY = 12;
  localparam int SB_NAE    = 13;
  localparam int SB_NAF    = 14;
  localparam int SB_NFULL  = 15;
  localparam int SB_UNDER  = 22;
  localparam int SB_OVER   = 23;

  typedef struct packed {
    logic empty;
    logic aempty;
    logic afull;
    logic full;
  } rxf_flags_t;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata_q
);
  logic [WIDTH-1:0] store [DEPTH];

  // single write port, registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata_q <= store[raddr];
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CMP_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [15:0]      ae_lvl,
  input  logic [7:0]       af_lvl,
  output logic             wr_en,
  output logic [AW-1:0]    wr_ptr,
  output logic             rd_en,
  output logic [AW-1:0]    rd_ptr,
  output logic [CNT_W-1:0] count,
  output rxf_flags_t       flags,
  output logic             ovr_evt,
  output logic             und_evt,
  output logic             nonempty_q
);
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q, wr_inc, rd_inc;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             push_ok, pop_ok;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_inc = wr_ptr_q + 1'b1;
      assign rd_inc = rd_ptr_q + 1'b1;
    end else begin : g_wrap
      assign wr_inc = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_inc = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
  endgenerate

  always_comb begin
    flags.empty  = (cnt_q == '0);
    flags.full   = (cnt_q == CNT_W'(DEPTH));
    flags.aempty = (CMP_W'(cnt_q) <= CMP_W'(ae_lvl));
    flags.afull  = ((CMP_W'(cnt_q) + CMP_W'(af_lvl)) >= CMP_W'(DEPTH));
  end

  assign push_ok = push_req && !flags.full;
  assign pop_ok  = pop_req && !flags.empty;
  assign ovr_evt = push_req && flags.full;
  assign und_evt = pop_req && flags.empty;

  always_comb begin
    cnt_nxt = cnt_q;
    if (flush)                  cnt_nxt = '0;
    else if (push_ok && !pop_ok) cnt_nxt = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      cnt_q      <= '0;
      nonempty_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_nxt;
      nonempty_q <= (cnt_nxt != '0);
      if (flush) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (push_ok) wr_ptr_q <= wr_inc;
        if (pop_ok)  rd_ptr_q <= rd_inc;
      end
    end
  end

  assign wr_en  = push_ok && !flush;
  assign wr_ptr = wr_ptr_q;
  assign rd_en  = pop_ok;
  assign rd_ptr = rd_ptr_q;
  assign count  = cnt_q;
endmodule

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SETTLE_CYCLES = 2500,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BSY_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_waddr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic [IDX_W-1:0]  reg_raddr,
  input  rxf_flags_t        flags,
  input  logic [CNT_W-1:0]  count,
  input  logic              ovr_evt,
  input  logic              und_evt,
  output logic              enable_q,
  output logic              busy,
  output logic              flush,
  output logic              srst,
  output logic [15:0]       ae_lvl,
  output logic [7:0]        af_lvl,
  output logic [WORD_W-1:0] csr_q
);
  logic [BSY_W-1:0] bsy_cnt_q;
  logic             over_q, under_q;
  logic             wr_ctrl, wr_stat, wr_level;
  logic             clr_over, clr_under;
  logic [WORD_W-1:0] rd_val;

  assign wr_ctrl   = reg_wr && (reg_waddr == IDX_CTRL);
  assign wr_stat   = reg_wr && (reg_waddr == IDX_STAT);
  assign wr_level  = reg_wr && (reg_waddr == IDX_LEVEL);
  assign srst      = wr_ctrl && reg_wdata[CB_SRST];
  assign flush     = wr_ctrl && reg_wdata[CB_FLUSH];
  assign clr_over  = wr_stat && reg_wdata[SB_OVER];
  assign clr_under = wr_stat && reg_wdata[SB_UNDER];
  assign busy      = (bsy_cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q  <= 1'b0;
      ae_lvl    <= 16'(LEVEL_DEFAULT);
      af_lvl    <= 8'(LEVEL_DEFAULT);
      over_q    <= 1'b0;
      under_q   <= 1'b0;
      bsy_cnt_q <= '0;
    end else if (srst) begin
      enable_q  <= 1'b0;
      ae_lvl    <= 16'(LEVEL_DEFAULT);
      af_lvl    <= 8'(LEVEL_DEFAULT);
      over_q    <= 1'b0;
      under_q   <= 1'b0;
      bsy_cnt_q <= BSY_W'(SETTLE_CYCLES);
    end else begin
      if (busy) bsy_cnt_q <= bsy_cnt_q - 1'b1;
      if (wr_ctrl) enable_q <= reg_wdata[CB_EN];
      if (wr_level) begin
        ae_lvl <= reg_wdata[15:0];
        af_lvl <= reg_wdata[23:16];
      end
      // an event in the same cycle as its clear keeps the bit set
      over_q  <= ovr_evt || (over_q && !clr_over);
      under_q <= und_evt || (under_q && !clr_under);
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (reg_raddr)
      IDX_CTRL: begin
        rd_val[CB_EN]   = enable_q;
        rd_val[CB_SRST] = busy;
      end
      IDX_STAT: begin
        rd_val[SB_NEMPTY] = !flags.empty;
        rd_val[SB_NAE]    = !flags.aempty;
        rd_val[SB_NAF]    = !flags.afull;
        rd_val[SB_NFULL]  = !flags.full;
        rd_val[SB_UNDER]  = under_q;
        rd_val[SB_OVER]   = over_q;
      end
      IDX_LEVEL: rd_val = {8'h00, af_lvl, ae_lvl};
      IDX_SIZE:  rd_val[19:0] = 20'(DEPTH);
      IDX_FILL:  rd_val[19:0] = 20'(count);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) csr_q <= '0;
    else if (reg_rd) csr_q <= rd_val;
  end
endmodule

// File: rtl/rx_level_fifo.sv
module rx_level_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SETTLE_CYCLES = 2500
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        reg_wr,
  input  logic [2:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  input  logic [2:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        dma_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              enable_q, busy, flush, srst;
  logic [15:0]       ae_lvl;
  logic [7:0]        af_lvl;
  logic              push_req, pop_req;
  logic              wr_en, rd_en, ovr_evt, und_evt, nonempty_q;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  rxf_flags_t        flags;
  logic [WORD_W-1:0] mem_q, csr_q;
  logic              sel_data_q, zero_q;

  assign push_req = in_valid && enable_q && !busy;
  assign pop_req  = reg_rd && (reg_raddr == IDX_DATA) && !busy;

  rxf_regs #(.DEPTH(DEPTH), .SETTLE_CYCLES(SETTLE_CYCLES)) u_regs (
    .clk, .rst, .reg_wr, .reg_waddr, .reg_wdata, .reg_rd, .reg_raddr,
    .flags, .count, .ovr_evt, .und_evt,
    .enable_q, .busy, .flush, .srst, .ae_lvl, .af_lvl, .csr_q
  );

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rst, .flush(flush || srst), .push_req, .pop_req, .ae_lvl, .af_lvl,
    .wr_en, .wr_ptr, .rd_en, .rd_ptr, .count, .flags, .ovr_evt, .und_evt,
    .nonempty_q
  );

  rxf_mem #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk, .we(wr_en), .waddr(wr_ptr), .wdata(in_data),
    .re(rd_en), .raddr(rd_ptr), .rdata_q(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_data_q <= 1'b0;
      zero_q     <= 1'b1;
    end else if (reg_rd) begin
      sel_data_q <= (reg_raddr == IDX_DATA);
      zero_q     <= !rd_en;
    end
  end

  assign reg_rdata = sel_data_q ? (zero_q ? '0 : mem_q) : csr_q;
  assign dma_ready = nonempty_q;
endmodule

// File: rtl/rx_level_fifo_chk.sv
module rx_level_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [2:0]       reg_waddr,
  input logic [31:0]      reg_wdata,
  input logic             enable_q,
  input logic             busy,
  input logic [CNT_W-1:0] count,
  input logic             dma_ready,
  input logic [31:0]      stat_over,
  input logic [15:0]      ae_lvl,
  input logic [7:0]       af_lvl
);
  logic clr_over, srst_wr;
  assign clr_over = reg_wr && (reg_waddr == 3'd1) && reg_wdata[23];
  assign srst_wr  = reg_wr && (reg_waddr == 3'd0) && reg_wdata[0];

  p_fill_bound_r12: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_ready_tracks_fill_r13: assert property (@(posedge clk) disable iff (rst)
    dma_ready == (count != '0));

  p_no_accept_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    !enable_q |=> count <= $past(count));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_over[0] && !clr_over && !srst_wr) |=> stat_over[0]);

  p_busy_empty_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> count == '0);

  p_levels_default_r11: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> (ae_lvl == 16'd32 && af_lvl == 8'd32));
endmodule

bind rx_level_fifo rx_level_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk, .rst, .reg_wr, .reg_waddr, .reg_wdata,
  .enable_q, .busy, .count, .dma_ready,
  .stat_over({31'd0, u_regs.over_q}),
  .ae_lvl, .af_lvl
);

// File: tb/test_rx_level_fifo.sv
module test_rx_level_fifo;
  localparam int DEPTH = 64;
  localparam int SETTLE = 2500;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_LEVEL = 3'd2,
                         A_SIZE = 3'd3, A_FILL = 3'd4, A_DATA = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic dma_ready;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rx_level_fifo #(.DEPTH(DEPTH), .SETTLE_CYCLES(SETTLE)) i_rx_level_fifo (
    .clk, .rst, .in_valid, .in_data, .reg_wr, .reg_waddr, .reg_wdata,
    .reg_rd, .reg_raddr, .reg_rdata, .dma_ready
  );

  function automatic logic [31:0] word_of(int i);
    return 32'hA500_0000 + 32'(i * 7);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_raddr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); in_valid = 1'b1; in_data = w;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_STAT, v);  chk("R1 status", v, 32'h0000_C000);
    rd(A_LEVEL, v); chk("R1 levels", v, 32'h0020_0020);
    rd(A_CTRL, v);  chk("R1 control", v, 32'h0);
    rd(A_SIZE, v);  chk("R12 size", v, 32'(DEPTH));
    rd(A_FILL, v);  chk("R1 fill", v, 32'h0);
    chk("R1 dma_ready", {31'd0, dma_ready}, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    for (int i = 0; i < 3; i++) push(32'hBAD0_0000 + 32'(i));
    rd(A_FILL, v); chk("R2 disabled fill", v, 32'h0);
    rd(A_STAT, v); chk("R2 no error", v, 32'h0000_C000);
    wr(A_CTRL, 32'h20);
    for (int i = 0; i < 5; i++) push(word_of(i));
    rd(A_FILL, v); chk("R12 fill five", v, 32'd5);
    rd(A_STAT, v); chk("R4 R5 status five", v, 32'h0000_D000);
    chk("R13 ready set", {31'd0, dma_ready}, 32'h1);
    for (int i = 0; i < 5; i++) begin
      rd(A_DATA, v); chk("R3 order", v, word_of(i));
    end
    chk("R13 ready clear", {31'd0, dma_ready}, 32'h0);
    rd(A_STAT, v); chk("R4 empty again", v, 32'h0000_C000);
  endtask

  task automatic t_levels;
    logic [31:0] v;
    wr(A_LEVEL, 32'h0004_0003);
    rd(A_LEVEL, v); chk("R5 R6 levels", v, 32'h0004_0003);
    for (int i = 1; i <= DEPTH; i++) begin
      push(word_of(100 + i));
      if (i == 3)  begin rd(A_STAT, v); chk("R5 at ae level", v, 32'h0000_D000); end
      if (i == 4)  begin rd(A_STAT, v); chk("R5 above ae", v, 32'h0000_F000); end
      if (i == 59) begin rd(A_STAT, v); chk("R6 below af", v, 32'h0000_F000); end
      if (i == 60) begin rd(A_STAT, v); chk("R6 at af", v, 32'h0000_B000); end
      if (i == 64) begin rd(A_STAT, v); chk("R4 full", v, 32'h0000_3000); end
    end
    push(32'hDEAD_BEEF);
    rd(A_STAT, v); chk("R7 overrun", v, 32'h0080_3000);
    rd(A_FILL, v); chk("R7 fill kept", v, 32'(DEPTH));
    for (int i = 1; i <= DEPTH; i++) begin
      rd(A_DATA, v); chk("R3 R7 drain", v, word_of(100 + i));
    end
    rd(A_DATA, v); chk("R8 empty read", v, 32'h0);
    rd(A_FILL, v); chk("R8 fill zero", v, 32'h0);
    rd(A_STAT, v); chk("R8 underrun", v, 32'h00C0_C000);
    wr(A_STAT, 32'h0080_0000);
    rd(A_STAT, v); chk("R9 clear overrun", v, 32'h0040_C000);
    wr(A_STAT, 32'h0040_0000);
    rd(A_STAT, v); chk("R9 clear underrun", v, 32'h0000_C000);
    // underrun event and its clear in one cycle
    @(negedge clk);
    reg_rd = 1'b1; reg_raddr = A_DATA;
    reg_wr = 1'b1; reg_waddr = A_STAT; reg_wdata = 32'h0040_0000;
    @(negedge clk); reg_rd = 1'b0; reg_wr = 1'b0;
    rd(A_STAT, v); chk("R9 set wins", v, 32'h0040_C000);
    wr(A_STAT, 32'h0040_0000);
  endtask

  task automatic t_flush;
    logic [31:0] v;
    push(32'h1111_0001); push(32'h1111_0002);
    wr(A_CTRL, 32'h24);
    rd(A_FILL, v); chk("R10 flushed", v, 32'h0);
    chk("R10 ready low", {31'd0, dma_ready}, 32'h0);
    rd(A_CTRL, v); chk("R10 enable kept", v, 32'h20);
    push(32'h0000_1234);
    rd(A_DATA, v); chk("R10 data after flush", v, 32'h0000_1234);
  endtask

  task automatic t_softreset;
    logic [31:0] v;
    wr(A_LEVEL, 32'h0005_0005);
    push(32'h2222_0001);
    rd(A_DATA, v); rd(A_DATA, v);   // second read leaves underrun set
    push(32'h2222_0002);
    wr(A_CTRL, 32'h21);
    rd(A_CTRL, v);  chk("R11 busy", v, 32'h1);
    rd(A_LEVEL, v); chk("R11 levels default", v, 32'h0020_0020);
    rd(A_FILL, v);  chk("R11 emptied", v, 32'h0);
    rd(A_STAT, v);  chk("R11 errors cleared", v, 32'h0000_C000);
    wr(A_CTRL, 32'h20);
    push(32'h3333_0001);
    rd(A_FILL, v);  chk("R11 no store busy", v, 32'h0);
    rd(A_DATA, v);  chk("R11 busy data", v, 32'h0);
    rd(A_STAT, v);  chk("R11 no underrun busy", v, 32'h0000_C000);
    repeat (SETTLE) @(negedge clk);
    rd(A_CTRL, v);  chk("R11 settled", v, 32'h20);
    push(32'h4444_0001);
    rd(A_FILL, v);  chk("R11 accepts after", v, 32'h1);
    rd(A_DATA, v);  chk("R11 data after", v, 32'h4444_0001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_enable();
    t_levels();
    t_flush();
    t_softreset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule